// File: doc/BRIEF.md
# Strip Hit Cluster Stream Generator

This block replays one fixed silicon-strip hit cluster as a burst of 24-bit words for a serial link transmitter that runs in 16-bit mode. Each word carries an 8-bit control byte in bits [23:16] and a 16-bit payload in bits [15:0]. While idle, the block sends filler words. A built-in periodic trigger starts a delay counter. When the delay expires, the block sends a twenty-word record and then returns to filler.

The trigger pulse is also driven out of the block. A companion generator for the track stream can start from the same event, so the strip record lags the track record by the programmed delay (about 5 µs, 265 cycles at 53 MHz). A trigger is ignored while an earlier one is still counting down or its record is still going out. Both the trigger period and the delay are parameters, so they can be set small for simulation.

Top module: `strip_cluster_gen`

## Requirements
- R1: While reset is held low, `link_word_o` is the filler word 0xF00303 and `trig_o` is 0. Reset can be applied in the middle of a record, and the next cycle shows this state.
- R2: `trig_o` is a one-cycle pulse. The first pulse comes PERIOD_CYCLES cycles after reset is released, and pulses then repeat every PERIOD_CYCLES cycles.
- R3: Outside a record, every word has control byte 0xF0 and logical payload 0xC0C0.
- R4: If a trigger is accepted in cycle T, the first record word appears in cycle T+START_DELAY.
- R5: The record opens with four words in this order, each with control 0xB0: sequencer 0x0505, HDI status/index 0x0504, chip 0x8484, and a zero word 0x0000.
- R6: Seven channel/data pairs follow, channel word first in each pair, all with control 0xB0. The logical payloads are 0202/0808, 0303/0B0B, 0404/1D0D, 0505/0B0B, 0606/0F0F, 0707/0B0B and 0808/0B0B.
- R7: Two end words with control 0xB0 and logical payload 0xC0C0 close the record, for 20 record words in total. Filler follows in the next cycle.
- R8: On the wire, payload bit i equals logical payload bit 15-i, so 0x0505 goes out as 0xA0A0 and 0x8484 as 0x2121. The control byte is not reordered.
- R9: A trigger that arrives while the delay is counting or a record is being sent is ignored. The current record goes out unchanged, and the next trigger that arrives while the block is idle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_o | output | 1 | Periodic trigger pulse, shared with the track stream |
| link_word_o | output | 24 | Control byte [23:16] and bit-reversed payload [15:0] |

## Verification
The bench builds two instances. The first uses a 64-cycle period and a 12-cycle delay, so the trigger spacing, the delay alignment, all twenty record words and a reset in the middle of a record all fit within a few hundred cycles. The second uses a 16-cycle period and a 6-cycle delay. With those values every other trigger lands while a record is being sent. This exercises the rule that such triggers are ignored, and shows that the following idle-time trigger is still taken.

// File: rtl/strip_gen_pkg.sv
package strip_gen_pkg;

    localparam int unsigned CTRL_W    = 8;
    localparam int unsigned PAY_W     = 16;
    localparam int unsigned WORD_W    = CTRL_W + PAY_W;
    localparam int unsigned HDR_WORDS = 4;
    localparam int unsigned HIT_COUNT = 7;
    localparam int unsigned END_WORDS = 2;
    localparam int unsigned REC_WORDS = HDR_WORDS + 2 * HIT_COUNT + END_WORDS;
    localparam int unsigned IDX_W     = $clog2(REC_WORDS);

    localparam logic [CTRL_W-1:0] CTRL_FILL = 8'hF0;
    localparam logic [CTRL_W-1:0] CTRL_REC  = 8'hB0;
    localparam logic [PAY_W-1:0]  PAY_FILL  = 16'hC0C0;

    typedef logic [IDX_W-1:0] rec_idx_t;

    typedef struct packed {
        logic [CTRL_W-1:0] ctrl;
        logic [PAY_W-1:0]  pay;
    } link_word_t;

    localparam link_word_t FILL_WORD = '{ctrl: CTRL_FILL, pay: PAY_FILL};

    // ADC payload of hit h (0-based)
    function automatic logic [PAY_W-1:0] hit_adc(input int unsigned h);
        case (h)
            0:       return 16'h0808;
            2:       return 16'h1D0D;
            4:       return 16'h0F0F;
            default: return 16'h0B0B;
        endcase
    endfunction

    // Channel payload of hit h: channel number in both bytes
    function automatic logic [PAY_W-1:0] hit_chan(input int unsigned h);
        logic [7:0] ch;
        ch = 8'(h + 32'd2);
        return {ch, ch};
    endfunction

    // Logical payload of record word idx
    function automatic logic [PAY_W-1:0] rec_payload(input int unsigned idx);
        int unsigned off;
        if (idx < HDR_WORDS) begin
            case (idx)
                0:       return 16'h0505;
                1:       return 16'h0504;
                2:       return 16'h8484;
                default: return 16'h0000;
            endcase
        end else if (idx < HDR_WORDS + 2 * HIT_COUNT) begin
            off = idx - HDR_WORDS;
            if ((off % 2) == 1) return hit_adc(off / 2);
            else                return hit_chan(off / 2);
        end
        return PAY_FILL;
    endfunction

    function automatic link_word_t rec_word(input int unsigned idx);
        link_word_t w;
        w.ctrl = CTRL_REC;
        w.pay  = rec_payload(idx);
        return w;
    endfunction

endpackage

// File: rtl/strip_trig_gen.sv
module strip_trig_gen #(
    parameter int unsigned PERIOD = 53_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic trig_o
);
    localparam int unsigned CNT_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             trig;
    } trig_state_t;

    localparam trig_state_t TRIG_RESET = '{cnt: '0, trig: 1'b0};

    trig_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.trig = 1'b0;
        if (st_q.cnt == CNT_LAST) begin
            st_d.cnt  = '0;
            st_d.trig = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= TRIG_RESET;
        else        st_q <= st_d;
    end

    assign trig_o = st_q.trig;

endmodule

// File: rtl/strip_start_delay.sv
module strip_start_delay #(
    parameter int unsigned DELAY = 265
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_i,
    input  logic rec_busy_i,
    output logic armed_o,
    output logic go_o
);
    // go is raised one cycle before the first record word is registered
    localparam int unsigned CNT_W = (DELAY > 4) ? $clog2(DELAY - 2) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DELAY - 3);

    typedef struct packed {
        logic             armed;
        logic [CNT_W-1:0] cnt;
        logic             go;
    } dly_state_t;

    localparam dly_state_t DLY_RESET = '{armed: 1'b0, cnt: '0, go: 1'b0};

    dly_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.go = 1'b0;
        if (st_q.armed) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.armed = 1'b0;
                st_d.cnt   = '0;
                st_d.go    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (trig_i && !st_q.go && !rec_busy_i) begin
            st_d.armed = 1'b1;
            st_d.cnt   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DLY_RESET;
        else        st_q <= st_d;
    end

    assign armed_o = st_q.armed;
    assign go_o    = st_q.go;

endmodule

// File: rtl/strip_record_seq.sv
module strip_record_seq
    import strip_gen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    output logic       active_o,
    output logic       last_o,
    output link_word_t word_o
);
    localparam rec_idx_t IDX_LAST = IDX_W'(REC_WORDS - 1);

    typedef struct packed {
        logic       active;
        rec_idx_t   idx;
        link_word_t word;
    } seq_state_t;

    localparam seq_state_t SEQ_RESET = '{active: 1'b0, idx: '0, word: FILL_WORD};

    seq_state_t st_d, st_q;
    rec_idx_t   idx_next;

    always_comb begin
        st_d     = st_q;
        idx_next = st_q.idx + 1'b1;
        if (st_q.active) begin
            if (st_q.idx == IDX_LAST) begin
                st_d.active = 1'b0;
                st_d.idx    = '0;
                st_d.word   = FILL_WORD;
            end else begin
                st_d.idx  = idx_next;
                st_d.word = rec_word(int'(idx_next));
            end
        end else if (go_i) begin
            st_d.active = 1'b1;
            st_d.idx    = '0;
            st_d.word   = rec_word(0);
        end else begin
            st_d.word = FILL_WORD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEQ_RESET;
        else        st_q <= st_d;
    end

    assign active_o = st_q.active;
    assign last_o   = st_q.active && (st_q.idx == IDX_LAST);
    assign word_o   = st_q.word;

endmodule

// File: rtl/strip_word_fmt.sv
module strip_word_fmt
    import strip_gen_pkg::*;
#(
    parameter bit REVERSE = 1'b1
) (
    input  link_word_t        word_i,
    output logic [WORD_W-1:0] wire_o
);
    assign wire_o[WORD_W-1:PAY_W] = word_i.ctrl;

    generate
        if (REVERSE) begin : g_rev
            for (genvar i = 0; i < PAY_W; i++) begin : g_bit
                assign wire_o[i] = word_i.pay[PAY_W-1-i];
            end
        end else begin : g_fwd
            assign wire_o[PAY_W-1:0] = word_i.pay;
        end
    endgenerate

endmodule

// File: rtl/strip_cluster_gen.sv
module strip_cluster_gen
    import strip_gen_pkg::*;
#(
    parameter int unsigned PERIOD_CYCLES   = 53_000_000,
    parameter int unsigned START_DELAY     = 265,
    parameter bit          REVERSE_PAYLOAD = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              trig_o,
    output logic [WORD_W-1:0] link_word_o
);
    logic       trig_w;
    logic       dly_armed;
    logic       start_go;
    logic       rec_active;
    logic       rec_last;
    link_word_t rec_word_w;

    strip_trig_gen #(.PERIOD(PERIOD_CYCLES)) trig_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig_o (trig_w)
    );

    strip_start_delay #(.DELAY(START_DELAY)) dly_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_i     (trig_w),
        .rec_busy_i (rec_active),
        .armed_o    (dly_armed),
        .go_o       (start_go)
    );

    strip_record_seq seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_i     (start_go),
        .active_o (rec_active),
        .last_o   (rec_last),
        .word_o   (rec_word_w)
    );

    strip_word_fmt #(.REVERSE(REVERSE_PAYLOAD)) fmt_i (
        .word_i (rec_word_w),
        .wire_o (link_word_o)
    );

    assign trig_o = trig_w;

endmodule

// File: rtl/strip_cluster_gen_chk.sv
module strip_cluster_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        trig_o,
    input logic [23:0] link_word_o,
    input logic        dly_armed,
    input logic        start_go,
    input logic        rec_active,
    input logic        rec_last
);
    // R2: trigger lasts exactly one cycle
    a_r2_trig_single: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |=> !trig_o);

    // R3: no record in flight means filler control on the wire
    a_r3_idle_fill: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_active |-> link_word_o[23:16] == 8'hF0);

    // R4: the start pulse opens a record in the next cycle
    a_r4_go_opens_record: assert property (@(posedge clk) disable iff (!rst_n)
        start_go |=> (rec_active && link_word_o[23:16] == 8'hB0));

    // R7: after the last record word the link returns to filler
    a_r7_last_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
        rec_last |=> (!rec_active && link_word_o[23:16] == 8'hF0));

    // R9: a trigger during the countdown does not drop it
    a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (dly_armed && trig_o) |=> (dly_armed || start_go));

    // R9: a start never lands inside a record
    a_r9_no_go_in_record: assert property (@(posedge clk) disable iff (!rst_n)
        start_go |-> !rec_active);

endmodule

bind strip_cluster_gen strip_cluster_gen_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_o      (trig_o),
    .link_word_o (link_word_o),
    .dly_armed   (dly_armed),
    .start_go    (start_go),
    .rec_active  (rec_active),
    .rec_last    (rec_last)
);

// File: tb/strip_cluster_gen_tb_top.sv
module strip_cluster_gen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int A_PERIOD   = 64;
    localparam int A_DELAY    = 12;
    localparam int B_PERIOD   = 16;
    localparam int B_DELAY    = 6;
    localparam int N_REC      = 20;
    localparam int WATCHDOG   = 20000;

    localparam logic [23:0] FILL_LOGICAL = 24'hF0C0C0;

    // expected logical record: control byte and unreversed payload
    localparam logic [23:0] EXP_REC [N_REC] = '{
        24'hB00505, 24'hB00504, 24'hB08484, 24'hB00000,
        24'hB00202, 24'hB00808, 24'hB00303, 24'hB00B0B,
        24'hB00404, 24'hB01D0D, 24'hB00505, 24'hB00B0B,
        24'hB00606, 24'hB00F0F, 24'hB00707, 24'hB00B0B,
        24'hB00808, 24'hB00B0B, 24'hB0C0C0, 24'hB0C0C0
    };

    logic        clk = 1'b0;
    logic        rst_a_n = 1'b0;
    logic        rst_b_n = 1'b0;
    logic        trig_a, trig_b;
    logic [23:0] word_a, word_b;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    strip_cluster_gen #(.PERIOD_CYCLES(A_PERIOD), .START_DELAY(A_DELAY)) dut_i (
        .clk         (clk),
        .rst_n       (rst_a_n),
        .trig_o      (trig_a),
        .link_word_o (word_a)
    );

    strip_cluster_gen #(.PERIOD_CYCLES(B_PERIOD), .START_DELAY(B_DELAY)) dut_b (
        .clk         (clk),
        .rst_n       (rst_b_n),
        .trig_o      (trig_b),
        .link_word_o (word_b)
    );

    // wire image of a logical word: payload bit i comes from bit 15-i
    function automatic logic [23:0] on_wire(input logic [23:0] w);
        logic [23:0] r;
        r[23:16] = w[23:16];
        for (int i = 0; i < 16; i++) r[i] = w[15-i];
        return r;
    endfunction

    function automatic string rec_tag(input int k);
        if (k < 4)  return "R5";
        if (k < 18) return "R6";
        return "R7";
    endfunction

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_trig_a(output int cycles);
        cycles = 0;
        do begin
            @(negedge clk);
            cycles++;
        end while (!trig_a);
    endtask

    task automatic flow_a();
        int cyc;
        rst_a_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset word", word_a, 24'hF00303);
        check("R1 reset trig", {23'b0, trig_a}, 24'h0);
        rst_a_n = 1'b1;
        wait_trig_a(cyc);
        check("R2 first trigger", 24'(cyc), 24'(A_PERIOD));
        for (int k = 1; k < A_DELAY; k++) begin
            @(negedge clk);
            check("R3 filler during delay", word_a, on_wire(FILL_LOGICAL));
        end
        for (int k = 0; k < N_REC; k++) begin
            @(negedge clk);
            check(rec_tag(k), word_a, on_wire(EXP_REC[k]));
            if (k == 0) check("R8 seq on wire", word_a, 24'hB0A0A0);
            if (k == 2) check("R8 chip on wire", word_a, 24'hB02121);
        end
        @(negedge clk);
        check("R7 filler after end", word_a, on_wire(FILL_LOGICAL));
        wait_trig_a(cyc);
        check("R2 trigger period", 24'(cyc + A_DELAY + N_REC), 24'(A_PERIOD));
        repeat (A_DELAY - 1) @(negedge clk);
        check("R4 not early", word_a, on_wire(FILL_LOGICAL));
        @(negedge clk);
        check("R4 record start", word_a, on_wire(EXP_REC[0]));
        repeat (5) @(negedge clk);
        rst_a_n = 1'b0;
        @(negedge clk);
        check("R1 mid-record reset word", word_a, 24'hF00303);
        check("R1 mid-record reset trig", {23'b0, trig_a}, 24'h0);
        @(negedge clk);
        rst_a_n = 1'b1;
        wait_trig_a(cyc);
        check("R2 trigger after reset", 24'(cyc), 24'(A_PERIOD));
        repeat (A_DELAY) @(negedge clk);
        check("R4 start after reset", word_a, on_wire(EXP_REC[0]));
    endtask

    task automatic flow_b();
        int cyc;
        logic [23:0] exp;
        rst_b_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_b_n = 1'b1;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!trig_b);
        check("R2 first trigger b", 24'(cyc), 24'(B_PERIOD));
        // records expected at offsets 6..25 and 38..57; trigger at 16 ignored
        for (int t = 1; t <= 60; t++) begin
            @(negedge clk);
            if (t >= B_DELAY && t < B_DELAY + N_REC)
                exp = on_wire(EXP_REC[t - B_DELAY]);
            else if (t >= 2 * B_PERIOD + B_DELAY && t < 2 * B_PERIOD + B_DELAY + N_REC)
                exp = on_wire(EXP_REC[t - 2 * B_PERIOD - B_DELAY]);
            else
                exp = on_wire(FILL_LOGICAL);
            check("R9 busy trigger ignored", word_b, exp);
            if (t == B_PERIOD || t == 2 * B_PERIOD)
                check("R9 trigger present", {23'b0, trig_b}, 24'h1);
        end
    endtask

    initial begin
        fork
            flow_a();
            flow_b();
        join
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL R2 watchdog: actual %0d cycles expected completion earlier", WATCHDOG);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule